// File: doc/BRIEF.md
# Dual-Section Latched Bus Transceiver

This block couples two 16-bit buses, A and B, through two independent 8-bit sections. Each section has two banks of transparent latches: one carries A data towards B and the other carries B data towards A. Each direction of each section has three active-low controls: a chip enable, a latch enable and an output enable. A section can therefore run as its own 8-bit transceiver. If the control pairs of both sections are tied together, the block acts as one 16-bit transceiver.

Each bus is modelled as a synthesizable tri-state port. A port has an input data vector, an output data vector and one drive-enable bit per section, and a pad ring outside the block resolves the three into a real bus. The latches are emulated with clocked storage. While a latch is open, its output follows the input with no delay, and the storage loads the input at every rising clock edge. When the latch closes, the storage keeps the value it loaded at the last edge before closing. Each section also has a flag that goes high whenever both of its directions drive at the same time.

Top module: `bus_xcvr16`

## Requirements
- R1: The sections are independent. The controls of one section never change the outputs, drive enables or stored data of the other section.
- R2: While a direction's chip enable is high, that direction's drive enable is 0 and its output data is 0. Its latch does not load, whatever the latch enable and output enable do. This is seen later as the old value when the direction is driven with its latch closed.
- R3: While a direction's output enable is high, that direction's drive is off. Its latch still opens and loads when chip enable and latch enable are low.
- R4: When chip enable, latch enable and output enable of a direction are all low, the destination output data equals the source input data in the same cycle.
- R5: When latch enable rises while chip enable is low, the latch keeps the source data sampled at the last rising clock edge at which it was open. That value is driven as long as chip enable and output enable stay low, and later source changes do not alter it. A capture needs latch enable low across at least one rising clock edge, with the data stable at that edge.
- R6: The B-to-A direction behaves exactly like A-to-B. It uses its own three controls, takes its source from B input data and drives the A port.
- R7: A section's contention flag is 1 exactly when that section's A-port drive enable and B-port drive enable are both 1.
- R8: While reset is low, every drive enable is 0 and every latch holds zero. After reset, a driven direction whose latch is closed shows 0.
- R9: Whenever a section's drive enable for a port is 0, that section's byte of the port's output data is 0.

Ports are listed section by section: bit i of each control vector belongs to section i, and section i occupies data bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; latch storage loads on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_ab_n | input | 2 | A-to-B chip enable per section, active low |
| le_ab_n | input | 2 | A-to-B latch enable per section, active low |
| oe_ab_n | input | 2 | A-to-B output enable per section, active low |
| ce_ba_n | input | 2 | B-to-A chip enable per section, active low |
| le_ba_n | input | 2 | B-to-A latch enable per section, active low |
| oe_ba_n | input | 2 | B-to-A output enable per section, active low |
| a_in | input | 16 | Data received from bus A |
| a_out | output | 16 | Data to drive onto bus A |
| a_drv | output | 2 | Per-section drive enable for bus A |
| b_in | input | 16 | Data received from bus B |
| b_out | output | 16 | Data to drive onto bus B |
| b_drv | output | 2 | Per-section drive enable for bus B |
| contend | output | 2 | Per-section flag: both directions drive at once |

## Verification
If a latch holds a wrong value, nothing shows at the ports until that direction is driven with its latch closed. The error then appears in the same cycle on the destination byte, so the bench drives closed latches often and compares each output byte against a model of the stored value. If a load is missed or spurious, the error shows on the first driven cycle after the latch closes. Drive and contention errors are combinational and show in the cycle of the control change.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_SECTIONS = 2;
    localparam int XCVR_LANE_W   = 8;

    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } xcvr_ctrl_t;

    function automatic logic ctrl_open(input xcvr_ctrl_t c);
        return ~(c.ce_n | c.le_n);
    endfunction

    function automatic logic ctrl_drive(input xcvr_ctrl_t c);
        return ~(c.ce_n | c.oe_n);
    endfunction

endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xcvr_ctrl_t        ctrl,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic              drive
);

    typedef struct packed {
        logic [LANE_W-1:0] store;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic        open_w;
    logic        drive_w;

    always_comb begin
        open_w  = ctrl_open(ctrl);
        drive_w = rst_n & ctrl_drive(ctrl);
        st_d    = st_q;
        if (open_w) begin
            st_d.store = din;
        end
        drive = drive_w;
        if (!drive_w) begin
            dout = '0;
        end else if (open_w) begin
            dout = din;
        end else begin
            dout = st_q.store;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CE_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ce_n |-> (!drive && dout == '0)); // R2

    AST_CAPTURE_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctrl.ce_n == 1'b0 && ctrl.le_n == 1'b0)
         && ctrl.le_n && drive) |-> dout == $past(din)); // R5

    AST_HOLD_WHILE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctrl.le_n) && $past(drive) && ctrl.le_n && drive
         && !ctrl.ce_n && !$past(ctrl.ce_n)) |-> $stable(dout)); // R5

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> dout == '0); // R9

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xcvr_ctrl_t        ab_ctrl,
    input  xcvr_ctrl_t        ba_ctrl,
    input  logic [LANE_W-1:0] a_in,
    input  logic [LANE_W-1:0] b_in,
    output logic [LANE_W-1:0] a_out,
    output logic [LANE_W-1:0] b_out,
    output logic              a_drv,
    output logic              b_drv,
    output logic              contend
);

    xcvr_lane #(.LANE_W(LANE_W)) ab_lane_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ab_ctrl),
        .din   (a_in),
        .dout  (b_out),
        .drive (b_drv)
    );

    xcvr_lane #(.LANE_W(LANE_W)) ba_lane_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ba_ctrl),
        .din   (b_in),
        .dout  (a_out),
        .drive (a_drv)
    );

    always_comb begin
        contend = a_drv & b_drv;
    end

    AST_CONTEND_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        contend |-> (!ab_ctrl.ce_n && !ab_ctrl.oe_n && !ba_ctrl.ce_n && !ba_ctrl.oe_n)); // R7

    AST_BOTH_GIVES_CONTEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_ctrl.ce_n && !ab_ctrl.oe_n && !ba_ctrl.ce_n && !ba_ctrl.oe_n) |-> contend); // R7

endmodule

// File: rtl/bus_xcvr16.sv
module bus_xcvr16
    import xcvr_pkg::*;
#(
    parameter int SECTIONS = XCVR_SECTIONS,
    parameter int LANE_W   = XCVR_LANE_W,
    localparam int BUS_W   = SECTIONS * LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SECTIONS-1:0] ce_ab_n,
    input  logic [SECTIONS-1:0] le_ab_n,
    input  logic [SECTIONS-1:0] oe_ab_n,
    input  logic [SECTIONS-1:0] ce_ba_n,
    input  logic [SECTIONS-1:0] le_ba_n,
    input  logic [SECTIONS-1:0] oe_ba_n,
    input  logic [BUS_W-1:0]    a_in,
    output logic [BUS_W-1:0]    a_out,
    output logic [SECTIONS-1:0] a_drv,
    input  logic [BUS_W-1:0]    b_in,
    output logic [BUS_W-1:0]    b_out,
    output logic [SECTIONS-1:0] b_drv,
    output logic [SECTIONS-1:0] contend
);

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        xcvr_ctrl_t ab_c, ba_c;

        always_comb begin
            ab_c = '{ce_n: ce_ab_n[s], le_n: le_ab_n[s], oe_n: oe_ab_n[s]};
            ba_c = '{ce_n: ce_ba_n[s], le_n: le_ba_n[s], oe_n: oe_ba_n[s]};
        end

        xcvr_section #(.LANE_W(LANE_W)) sec_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ab_ctrl (ab_c),
            .ba_ctrl (ba_c),
            .a_in    (a_in[s*LANE_W +: LANE_W]),
            .b_in    (b_in[s*LANE_W +: LANE_W]),
            .a_out   (a_out[s*LANE_W +: LANE_W]),
            .b_out   (b_out[s*LANE_W +: LANE_W]),
            .a_drv   (a_drv[s]),
            .b_drv   (b_drv[s]),
            .contend (contend[s])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_NO_DRIVE: assert (a_drv == '0 && b_drv == '0); // R8
        end
    end

endmodule

// File: tb/bus_xcvr16_tb_top.sv
module bus_xcvr16_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 2;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] ce_ab_n = '1, le_ab_n = '1, oe_ab_n = '1;
    logic [NS-1:0] ce_ba_n = '1, le_ba_n = '1, oe_ba_n = '1;
    logic [15:0]   a_in = '0, b_in = '0;
    logic [15:0]   a_out, b_out;
    logic [NS-1:0] a_drv, b_drv, contend;

    int checks = 0;
    int failures = 0;

    logic [W-1:0] m_ab [NS];
    logic [W-1:0] m_ba [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_xcvr16 dut_i (
        .clk(clk), .rst_n(rst_n),
        .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
        .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .contend(contend)
    );

    // reference storage, loaded from the requirements' latch rule
    always @(posedge clk or negedge rst_n) begin
        for (int s = 0; s < NS; s++) begin
            if (!rst_n) begin
                m_ab[s] <= '0;
                m_ba[s] <= '0;
            end else begin
                if (!ce_ab_n[s] && !le_ab_n[s]) m_ab[s] <= a_in[s*W +: W];
                if (!ce_ba_n[s] && !le_ba_n[s]) m_ba[s] <= b_in[s*W +: W];
            end
        end
    end

    function automatic logic exp_b_drv(int s);
        return rst_n && !ce_ab_n[s] && !oe_ab_n[s];
    endfunction
    function automatic logic exp_a_drv(int s);
        return rst_n && !ce_ba_n[s] && !oe_ba_n[s];
    endfunction
    function automatic logic [W-1:0] exp_b(int s);
        if (!exp_b_drv(s)) return '0;
        if (!le_ab_n[s]) return a_in[s*W +: W];
        return m_ab[s];
    endfunction
    function automatic logic [W-1:0] exp_a(int s);
        if (!exp_a_drv(s)) return '0;
        if (!le_ba_n[s]) return b_in[s*W +: W];
        return m_ba[s];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int s = 0; s < NS; s++) begin
            chk({tag, " b_drv"},  32'(b_drv[s]), 32'(exp_b_drv(s)));
            chk({tag, " a_drv"},  32'(a_drv[s]), 32'(exp_a_drv(s)));
            chk({tag, " b_out"},  32'(b_out[s*W +: W]), 32'(exp_b(s)));
            chk({tag, " a_out"},  32'(a_out[s*W +: W]), 32'(exp_a(s)));
            chk({tag, " R7 contend"}, 32'(contend[s]),
                32'(exp_a_drv(s) && exp_b_drv(s)));
        end
    endtask

    // drive just after negedge, sample one ns later
    task automatic step;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        // R8: reset state
        a_in = 16'hA5C3; b_in = 16'h3C5A;
        ce_ab_n = '0; oe_ab_n = '0; ce_ba_n = '0; oe_ba_n = '0;
        le_ab_n = '0; le_ba_n = '0;
        repeat (3) step;
        #1;
        chk("R8 reset a_drv", 32'(a_drv), 0);
        chk("R8 reset b_drv", 32'(b_drv), 0);
        chk("R8 R9 reset b_out", 32'(b_out), 0);
        chk("R8 reset contend", 32'(contend), 0);
        // hold latches closed through reset release
        le_ab_n = '1; le_ba_n = '1;
        step; rst_n = 1'b1;
        step; #1;
        chk("R8 held zero b_out", 32'(b_out), 0);
        chk("R8 held zero a_out", 32'(a_out), 0);
        check_all("R8");

        // R4: transparent both sections
        step; le_ab_n = '0; a_in = 16'h1234; ce_ba_n = '1; #1;
        chk("R4 transparent b_out", 32'(b_out), 32'h1234);
        check_all("R4");
        // R5: capture then change source
        step; le_ab_n = '1; a_in = 16'hFFFF; #1;
        chk("R5 held after close", 32'(b_out), 32'h1234);
        step; a_in = 16'h0F0F; #1;
        chk("R5 later change ignored", 32'(b_out), 32'h1234);

        // R2: chip enable high blocks load and drive
        step; ce_ab_n = '1; le_ab_n = '0; a_in = 16'hBEEF; #1;
        chk("R2 drive off", 32'(b_drv), 0);
        chk("R2 out zero", 32'(b_out), 0);
        step; step; le_ab_n = '1; step; ce_ab_n = '0; #1;
        chk("R2 no load while disabled", 32'(b_out), 32'h1234);

        // R3: output enable high still loads
        step; oe_ab_n = '1; le_ab_n = '0; a_in = 16'h5AA5; #1;
        chk("R3 no drive", 32'(b_drv), 0);
        chk("R9 undriven zero", 32'(b_out), 0);
        step; le_ab_n = '1; a_in = 16'h0000; step; oe_ab_n = '0; #1;
        chk("R3 loaded while undriven", 32'(b_out), 32'h5AA5);

        // R1: section 1 controls leave section 0 alone
        step; ce_ab_n = 2'b10; oe_ab_n = 2'b00; le_ab_n = 2'b01;
        a_in = 16'h7711; #1;
        chk("R1 section0 held", 32'(b_out[7:0]), 32'hA5);
        chk("R1 section1 off", 32'(b_out[15:8]), 0);
        step; ce_ab_n = 2'b01; le_ab_n = 2'b00; a_in = 16'h8822; #1;
        chk("R1 section1 transparent", 32'(b_out[15:8]), 32'h88);
        chk("R1 section0 off", 32'(b_out[7:0]), 0);

        // R6 and R7: B-to-A capture with contention
        step; ce_ab_n = '0; oe_ab_n = '0; le_ab_n = '1;
        ce_ba_n = '0; oe_ba_n = '0; le_ba_n = '0; b_in = 16'hC0DE; #1;
        chk("R6 transparent a_out", 32'(a_out), 32'hC0DE);
        chk("R7 both drive", 32'(contend), 32'h3);
        step; le_ba_n = '1; b_in = 16'h0000; #1;
        chk("R6 held a_out", 32'(a_out), 32'hC0DE);
        step; oe_ba_n = 2'b10; #1;
        chk("R7 one section", 32'(contend), 32'h1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            step;
            ce_ab_n = 2'($urandom() & ($urandom() | $urandom()));
            ce_ba_n = 2'($urandom() & ($urandom() | $urandom()));
            le_ab_n = 2'($urandom()); le_ba_n = 2'($urandom());
            oe_ab_n = 2'($urandom() & $urandom());
            oe_ba_n = 2'($urandom() & $urandom());
            a_in = 16'($urandom()); b_in = 16'($urandom());
            #1;
            check_all("R1 R4 R5 R6 R9 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule